// File: doc/BRIEF.md
# Serial Byte Receiver with Break-Triggered Wake-up

This block receives asynchronous 8N1 serial bytes from a single input line, timed by an externally supplied tick at sixteen times the bit rate. A completed byte is held in a data register, a receive flag is raised, and a software read strobe takes the byte and clears the flag. A framing-error flag reports a low stop bit. An overrun flag reports a byte that finished while the earlier one was still unread.

The block also has a wake-up mode. Software arms it with a one-cycle strobe before it lets the rest of the system sleep, and it should do so only while the idle status shows that no byte is in progress. While the mode is armed, byte reception is suspended and the receiver stays idle. The first high-to-low transition on the line sets the receive flag. The next low-to-high transition disarms the mode by itself and returns the receiver to normal operation.

Wake-up works on edges alone. The line should therefore stay low for the whole wake character: at least eight zero data bits, or a twelve-bit-time break. The data register read that clears a wake-up flag returns filler and should be thrown away.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, rx_flag, wake_en, frame_err and overrun are 0, and rx_idle is 1.
- R2: With wake_en at 0, a frame made of a low start bit, eight data bits sent LSB first and a stop bit is stored in rx_data, and rx_flag is set. Each bit lasts 16 ticks and is sampled at mid-bit.
- R3: A pulse on wake_set drives wake_en to 1. While wake_en is 1, no byte is received and rx_idle stays 1.
- R4: While armed, a high-to-low transition on rxd sets rx_flag, and wake_en stays 1 for as long as the line stays low.
- R5: After that falling edge, the first low-to-high transition on rxd returns wake_en to 0 by itself. A rising edge anywhere in the break therefore disarms early.
- R6: A pulse on rd_strobe clears rx_flag, and also clears overrun. rx_flag never clears in any other way.
- R7: rx_idle is 0 while a frame is being received and 1 otherwise.
- R8: If wake-up is armed while rxd is low, that low level causes no wake event. A wake event needs the line to go high and then fall.
- R9: The rising edge that ends a break is not taken as a start bit. No byte appears until a new falling edge begins a frame.
- R10: frame_err takes the value 1 when the stop bit of a completed frame is sampled low, and 0 when it is sampled high.
- R11: A frame that completes while rx_flag is still 1 sets overrun and leaves rx_data holding the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle tick at sixteen times the bit rate |
| wake_set | input | 1 | Strobe that arms wake-up mode |
| rd_strobe | input | 1 | Data register read strobe |
| rx_data | output | 8 | Last byte received |
| rx_flag | output | 1 | Receive flag, set by a byte or by a wake event |
| wake_en | output | 1 | Wake-up mode armed |
| rx_idle | output | 1 | No frame in progress |
| frame_err | output | 1 | Stop bit of the last completed frame was low |
| overrun | output | 1 | A byte was lost because the previous one was unread |

## Verification
The bench sends a long break while wake-up is armed. A design that let the receiver run during that time would take the break as a 0x00 byte with a framing error, or would clear the enable on the falling edge instead of the rising one.

It arms wake-up on a line that is already low. A design that treated the low level as an edge would wake at once, with no falling transition on the line.

It checks that the rising edge at the end of a break starts no frame. A level-triggered start detector would deliver a spurious byte there.

It also sends a frame with a low stop bit and two frames with no read between them. A wrong design would either miss the framing error or overwrite the unread byte.

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             tick16,
  input  logic             wake_set,
  input  logic             rd_strobe,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_flag,
  output logic             wake_en,
  output logic             rx_idle,
  output logic             frame_err,
  output logic             overrun
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DBITS + 1);
  localparam int HALF = OVS / 2 - 1;
  localparam int LAST = OVS - 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic       sy1, sy2, prv;
  logic       fall, rise;
  st_t        st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbit;
  logic [DBITS-1:0] sh;
  logic       seen_hi, woke;

  assign fall    = prv & ~sy2;
  assign rise    = ~prv & sy2;
  assign rx_idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1; sy2 <= 1'b1; prv <= 1'b1;
    end else begin
      sy1 <= rxd; sy2 <= sy1; prv <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en <= 1'b0; seen_hi <= 1'b0; woke <= 1'b0;
    end else if (wake_set) begin
      wake_en <= 1'b1; seen_hi <= 1'b0; woke <= 1'b0;
    end else if (wake_en) begin
      if (sy2) seen_hi <= 1'b1;
      if (!woke && seen_hi && fall) woke <= 1'b1;
      if (woke && rise) begin
        wake_en <= 1'b0;
        woke    <= 1'b0;
      end
    end
  end

  logic wake_evt;
  assign wake_evt = wake_en && !wake_set && !woke && seen_hi && fall;

  logic done;
  assign done = !wake_en && st == S_STOP && tick16 && cnt == CW'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; sh <= '0;
    end else if (wake_en || wake_set) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0;
    end else begin
      case (st)
        S_IDLE: if (fall) begin st <= S_START; cnt <= '0; end
        S_START: if (tick16) begin
          if (cnt == CW'(HALF)) begin
            cnt <= '0; nbit <= '0;
            st  <= sy2 ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(LAST)) begin
            sh   <= {sy2, sh[DBITS-1:1]};
            nbit <= nbit + 1'b1;
            if (nbit == BW'(DBITS - 1)) st <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(LAST)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_flag <= 1'b0; frame_err <= 1'b0; overrun <= 1'b0;
    end else begin
      if (rd_strobe) begin
        rx_flag <= 1'b0;
        overrun <= 1'b0;
      end
      if (wake_evt) rx_flag <= 1'b1;
      if (done) begin
        frame_err <= ~sy2;
        if (rx_flag) overrun <= 1'b1;
        else begin
          rx_data <= sh;
          rx_flag <= 1'b1;
        end
      end
    end
  end

  assert_idle_while_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |-> rx_idle);
  assert_disarm_on_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_en) |-> $past(sy2));
  assert_flag_clears_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(rd_strobe));
  assert_overrun_needs_unread_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_flag));
  assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> !$past(rx_flag));
  assert_wake_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && $rose(rx_flag)) |-> !$past(sy2));
endmodule

// File: tb/uart_rx_wake_tb.sv
module uart_rx_wake_tb;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b1;
  logic wake_set = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_flag, wake_en, rx_idle, frame_err, overrun;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  uart_rx_wake u_dut (.clk, .rst_n, .rxd, .tick16, .wake_set, .rd_strobe,
    .rx_data, .rx_flag, .wake_en, .rx_idle, .frame_err, .overrun);

  // {data, stop bit, expected frame_err}
  localparam logic [9:0] VEC [6] = '{
    {8'hA5, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b0}, {8'hFF, 1'b1, 1'b0},
    {8'h3C, 1'b0, 1'b1}, {8'h81, 1'b1, 1'b0}, {8'h5A, 1'b1, 1'b0}};

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_set = 1'b1; @(negedge clk); wake_set = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic stopb);
    @(negedge clk); rxd = 1'b0; clocks(16);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; clocks(16); end
    rxd = stopb; clocks(16);
    rxd = 1'b1; clocks(10);
  endtask

  initial begin
    #(5 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clocks(4); rst_n = 1'b1; clocks(4);
    chk(rx_flag, 0, "R1 flag"); chk(wake_en, 0, "R1 wake_en");
    chk(frame_err, 0, "R1 frame_err"); chk(overrun, 0, "R1 overrun");
    chk(rx_idle, 1, "R1 idle");

    foreach (VEC[k]) begin
      send(VEC[k][9:2], VEC[k][1]);
      chk(rx_flag, 1, "R2 flag");
      chk(rx_data, VEC[k][9:2], "R2 data");
      chk(frame_err, VEC[k][0], "R10 frame_err");
      pulse_rd(); clocks(1);
      chk(rx_flag, 0, "R6 read clears");
    end

    // rx_idle during a frame
    @(negedge clk); rxd = 1'b0; clocks(30);
    chk(rx_idle, 0, "R7 busy");
    rxd = 1'b1; clocks(16 * 12);
    chk(rx_idle, 1, "R7 idle after");
    if (rx_flag) pulse_rd();

    // wake-up with a 13-bit break
    pulse_wake(); clocks(3);
    chk(wake_en, 1, "R3 armed"); chk(rx_idle, 1, "R3 idle");
    rxd = 1'b0; clocks(8);
    chk(rx_flag, 1, "R4 wake flag");
    clocks(16 * 13);
    chk(wake_en, 1, "R4 still armed"); chk(rx_idle, 1, "R3 no rx in break");
    rxd = 1'b1; clocks(8);
    chk(wake_en, 0, "R5 auto clear");
    clocks(16 * 12);
    chk(rx_idle, 1, "R9 no start on rise");
    pulse_rd(); clocks(16 * 4);
    chk(rx_flag, 0, "R9 no byte after break");
    send(8'h6E, 1'b1);
    chk(rx_data, 8'h6E, "R2 byte after wake"); pulse_rd();

    // arm while line is low
    @(negedge clk); rxd = 1'b0; clocks(4);
    pulse_wake(); clocks(40);
    chk(rx_flag, 0, "R8 stale low no wake");
    rxd = 1'b1; clocks(20);
    chk(wake_en, 1, "R8 still armed"); chk(rx_flag, 0, "R8 no flag");
    rxd = 1'b0; clocks(8);
    chk(rx_flag, 1, "R8 wake on real fall");
    // glitch ends break early
    rxd = 1'b1; clocks(3); rxd = 1'b0; clocks(8);
    chk(wake_en, 0, "R5 early rise disarms");
    rxd = 1'b1; clocks(16 * 12);
    pulse_rd(); clocks(2);

    // overrun
    send(8'h11, 1'b1); send(8'h22, 1'b1);
    chk(overrun, 1, "R11 overrun"); chk(rx_data, 8'h11, "R11 data kept");
    pulse_rd(); clocks(1);
    chk(overrun, 0, "R6 overrun cleared"); chk(rx_flag, 0, "R6 flag cleared");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule